// File: doc/BRIEF.md
# Two-Wire Register Target Controller

This block is the target (slave) side of a two-wire I2C serial link that gives an external host access to a small register bank inside the chip. It samples the SCL and SDA lines with a fast system clock. Each line goes through a synchronizer and a stability filter, so short spikes are dropped. The block then finds START and STOP conditions and rising and falling clock edges. It shifts bytes in and out with the most significant bit first, and it pulls SDA low only through an open-drain enable.

A transfer opens with an identification byte. Its upper five bits are a fixed prefix. The next two bits must equal two strap inputs, so up to four of these blocks can share one bus. The last bit selects read or write. A write carries one register address byte and one data byte, and the data reaches the core through a one-cycle write strobe. A read first sets the register pointer in a write-mode phase. The host then issues a repeated START and a read-mode identification byte, and the block returns the byte that the core's read mux presents for that pointer.

Top module: `i2cr_target`

## Requirements
- R1: While reset is asserted and after it is released, sda_oe is 0 and reg_wr_en is 0 until a transfer drives them.
- R2: After a START, the first byte is acknowledged (SDA held low in the ninth clock) only if its bits 7..3 are 1,0,1,0,0 and its bits 2..1 equal strap[1:0]. Bit 0 selects the direction: 1 is read, 0 is write. A byte that does not match is not acknowledged, and no later byte is acknowledged until the next START.
- R3: A write is an identification byte with bit 0 = 0, then an address byte, then a data byte. All three are acknowledged. On the ninth rising clock of the data byte, reg_wr_en pulses for exactly one system cycle, with reg_wr_addr equal to the address byte and reg_wr_data equal to the data byte. Bits are received MSB first.
- R4: Within one write, any byte after the first data byte is not acknowledged and causes no write strobe.
- R5: A read is an identification byte with bit 0 = 0, then an address byte, then a repeated START, then an identification byte with bit 0 = 1. The block then sends reg_rd_data for reg_rd_addr = address byte, MSB first. It changes its SDA drive only while SCL is low.
- R6: When the host acknowledges a returned byte (SDA low in the ninth clock), the same register is sent again. When the host does not acknowledge (SDA high), the block releases SDA and leaves the bus untouched until the next START.
- R7: A STOP releases SDA and returns the block to idle. A byte clocked after a STOP without a new START is not acknowledged.
- R8: A pulse on SCL or SDA that lasts fewer than FILT_LEN system clock cycles has no effect on any transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 20 MHz |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| strap | input | 2 | Low two bits of the 7-bit target address |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |
| reg_wr_en | output | 1 | One-cycle register write strobe |
| reg_wr_addr | output | 8 | Register address for the write strobe |
| reg_wr_data | output | 8 | Data for the write strobe |
| reg_rd_addr | output | 8 | Register pointer presented to the core read mux |
| reg_rd_data | input | 8 | Read mux result for reg_rd_addr |

## Verification
Bus condition detection and bit shifting act on the same filtered lines. A spike on SDA while SCL is high therefore lands in the same cycles as an ongoing data byte, and unfiltered it would read as a STOP followed by a START. The bench injects a 3-cycle SDA spike while SCL is high and a 3-cycle SCL spike while SCL is low, both inside the data byte of a write. It judges the result by the write strobe that follows: it must come exactly once, carrying the intended address and data. A second overlap is the master-acknowledge clock of a read, where sampling the host's ACK and reloading the next byte happen in adjacent edges of the same bit. This is judged by repeated reads that return identical bytes, followed by a NACK after which the line reads all ones.

// File: rtl/i2cr_pkg.sv
package i2cr_pkg;
  localparam int BYTE_W = 8;
  localparam int STRAP_W = 2;
  localparam logic [4:0] ID_PREFIX = 5'b10100;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ID,
    PH_ADDR,
    PH_WDATA,
    PH_RDATA,
    PH_SKIP
  } phase_t;
endpackage

// File: rtl/i2cr_filter.sv
module i2cr_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  localparam int CW = $clog2(FILT_LEN + 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [CW-1:0]          cnt_q, cnt_d;
  logic                   out_q, out_d;

  always_comb begin
    cnt_d = cnt_q;
    out_d = out_q;
    if (sync_q[SYNC_STAGES-1] == out_q) begin
      cnt_d = '0;
    end else if (cnt_q == CW'(FILT_LEN - 1)) begin
      cnt_d = '0;
      out_d = sync_q[SYNC_STAGES-1];
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      cnt_q  <= '0;
      out_q  <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], din};
      cnt_q  <= cnt_d;
      out_q  <= out_d;
    end
  end

  assign dout = out_q;
endmodule

// File: rtl/i2cr_cond.sv
module i2cr_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_f,
  input  logic sda_f,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_f;
      sda_q <= sda_f;
    end
  end

  assign scl_rise  = scl_f & ~scl_q;
  assign scl_fall  = ~scl_f & scl_q;
  assign start_det = scl_f & scl_q & sda_q & ~sda_f;
  assign stop_det  = scl_f & scl_q & ~sda_q & sda_f;
endmodule

// File: rtl/i2cr_fsm.sv
module i2cr_fsm
  import i2cr_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sda_f,
  input  logic                scl_rise,
  input  logic                scl_fall,
  input  logic                start_det,
  input  logic                stop_det,
  input  logic [STRAP_W-1:0]  strap,
  input  logic [BYTE_W-1:0]   rd_data,
  output logic                sda_oe,
  output logic                wr_en,
  output logic [BYTE_W-1:0]   ptr,
  output logic [BYTE_W-1:0]   rx_byte
);
  phase_t            ph_q, ph_d;
  logic [3:0]        bit_q, bit_d;
  logic [BYTE_W-1:0] rx_q, rx_d;
  logic [BYTE_W-1:0] tx_q, tx_d;
  logic [BYTE_W-1:0] ptr_q, ptr_d;
  logic              oe_q, oe_d;
  logic              wr_q, wr_d;
  logic              mack_q, mack_d;
  logic              id_hit;
  logic              active;

  assign id_hit = (rx_q[7:3] == ID_PREFIX) && (rx_q[2:1] == strap);
  assign active = (ph_q != PH_IDLE) && (ph_q != PH_SKIP);

  always_comb begin
    ph_d   = ph_q;
    bit_d  = bit_q;
    rx_d   = rx_q;
    tx_d   = tx_q;
    ptr_d  = ptr_q;
    oe_d   = oe_q;
    mack_d = mack_q;
    wr_d   = 1'b0;
    if (start_det) begin
      ph_d  = PH_ID;
      bit_d = '0;
      oe_d  = 1'b0;
    end else if (stop_det) begin
      ph_d  = PH_IDLE;
      bit_d = '0;
      oe_d  = 1'b0;
    end else if (active) begin
      if (scl_rise) begin
        if (bit_q < 4'd8) begin
          rx_d  = {rx_q[BYTE_W-2:0], sda_f};
          bit_d = bit_q + 4'd1;
        end else if (bit_q == 4'd8) begin
          bit_d = 4'd9;
          if (ph_q == PH_WDATA) wr_d = 1'b1;
          if (ph_q == PH_RDATA) mack_d = ~sda_f;
        end
      end else if (scl_fall) begin
        if (bit_q == 4'd8) begin
          case (ph_q)
            PH_ID:    if (id_hit) oe_d = 1'b1; else ph_d = PH_SKIP;
            PH_ADDR,
            PH_WDATA: oe_d = 1'b1;
            default:  oe_d = 1'b0;
          endcase
        end else if (bit_q == 4'd9) begin
          bit_d = '0;
          oe_d  = 1'b0;
          case (ph_q)
            PH_ID: begin
              if (rx_q[0]) begin
                ph_d = PH_RDATA;
                tx_d = rd_data;
                oe_d = ~rd_data[BYTE_W-1];
              end else begin
                ph_d = PH_ADDR;
              end
            end
            PH_ADDR: begin
              ptr_d = rx_q;
              ph_d  = PH_WDATA;
            end
            PH_RDATA: begin
              if (mack_q) begin
                tx_d = rd_data;
                oe_d = ~rd_data[BYTE_W-1];
              end else begin
                ph_d = PH_SKIP;
              end
            end
            default: ph_d = PH_SKIP;
          endcase
        end else if ((ph_q == PH_RDATA) && (bit_q != 4'd0)) begin
          tx_d = {tx_q[BYTE_W-2:0], 1'b0};
          oe_d = ~tx_q[BYTE_W-2];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      bit_q  <= '0;
      rx_q   <= '0;
      tx_q   <= '0;
      ptr_q  <= '0;
      oe_q   <= 1'b0;
      wr_q   <= 1'b0;
      mack_q <= 1'b0;
    end else begin
      ph_q   <= ph_d;
      bit_q  <= bit_d;
      rx_q   <= rx_d;
      tx_q   <= tx_d;
      ptr_q  <= ptr_d;
      oe_q   <= oe_d;
      wr_q   <= wr_d;
      mack_q <= mack_d;
    end
  end

  assign sda_oe  = oe_q;
  assign wr_en   = wr_q;
  assign ptr     = ptr_q;
  assign rx_byte = rx_q;
endmodule

// File: rtl/i2cr_target.sv
module i2cr_target
  import i2cr_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_i,
  input  logic               sda_i,
  input  logic [STRAP_W-1:0] strap,
  output logic               sda_oe,
  output logic               reg_wr_en,
  output logic [BYTE_W-1:0]  reg_wr_addr,
  output logic [BYTE_W-1:0]  reg_wr_data,
  output logic [BYTE_W-1:0]  reg_rd_addr,
  input  logic [BYTE_W-1:0]  reg_rd_data
);
  localparam int NLINES = 2;

  logic [NLINES-1:0] line_raw, line_f;
  logic scl_f, sda_f;
  logic scl_rise, scl_fall, start_det, stop_det;
  logic [BYTE_W-1:0] ptr, rx_byte;

  assign line_raw = {scl_i, sda_i};

  for (genvar g = 0; g < NLINES; g++) begin : g_line
    i2cr_filter #(.SYNC_STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN)) u_filt (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (line_raw[g]),
      .dout (line_f[g])
    );
  end

  assign scl_f = line_f[1];
  assign sda_f = line_f[0];

  i2cr_cond u_cond (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_f    (scl_f),
    .sda_f    (sda_f),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_det(start_det),
    .stop_det (stop_det)
  );

  i2cr_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .sda_f    (sda_f),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_det(start_det),
    .stop_det (stop_det),
    .strap    (strap),
    .rd_data  (reg_rd_data),
    .sda_oe   (sda_oe),
    .wr_en    (reg_wr_en),
    .ptr      (ptr),
    .rx_byte  (rx_byte)
  );

  assign reg_wr_addr = ptr;
  assign reg_wr_data = rx_byte;
  assign reg_rd_addr = ptr;
endmodule

// File: rtl/i2cr_target_chk.sv
module i2cr_target_chk (
  input logic clk,
  input logic rst_n,
  input logic scl_f,
  input logic scl_rise,
  input logic start_det,
  input logic stop_det,
  input logic sda_oe,
  input logic reg_wr_en
);
  // R3
  wr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_en |=> !reg_wr_en);

  // R3
  wr_at_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_en |-> $past(scl_rise));

  // R5
  drive_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_f);

  // R7
  stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_oe);

  // R2
  start_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> !sda_oe);
endmodule

bind i2cr_target i2cr_target_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .scl_f    (scl_f),
  .scl_rise (scl_rise),
  .start_det(start_det),
  .stop_det (stop_det),
  .sda_oe   (sda_oe),
  .reg_wr_en(reg_wr_en)
);

// File: tb/tb_i2cr_target.sv
`timescale 1ns/1ps
module tb_i2cr_target;
  localparam int Q = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic [1:0] strap_b = 2'b00;
  logic sda_oe, reg_wr_en;
  logic [7:0] reg_wr_addr, reg_wr_data, reg_rd_addr, reg_rd_data;
  logic [7:0] mem [256];
  wire sda_bus = sda_m & ~sda_oe;

  int n_chk = 0, n_bad = 0;
  int wr_cnt = 0;
  logic [7:0] last_wa = '0, last_wd = '0;
  int gmode = 0;

  always #4 clk = ~clk;

  i2cr_target dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
    .strap(strap_b), .sda_oe(sda_oe), .reg_wr_en(reg_wr_en),
    .reg_wr_addr(reg_wr_addr), .reg_wr_data(reg_wr_data),
    .reg_rd_addr(reg_rd_addr), .reg_rd_data(reg_rd_data)
  );

  assign reg_rd_data = mem[reg_rd_addr];

  initial for (int i = 0; i < 256; i++) mem[i] = 8'(i) ^ 8'h5A;

  always @(posedge clk) if (reg_wr_en) begin
    mem[reg_wr_addr] <= reg_wr_data;
    wr_cnt <= wr_cnt + 1;
    last_wa <= reg_wr_addr;
    last_wd <= reg_wr_data;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wq(Q); scl_m = 1'b1; wq(Q);
    sda_m = 1'b0; wq(Q); scl_m = 1'b0; wq(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq(Q); scl_m = 1'b1; wq(Q); sda_m = 1'b1; wq(Q);
  endtask

  task automatic write_bit(input logic b, input bit g);
    sda_m = b;
    if (g && gmode == 2) begin
      wq(4); scl_m = 1'b1; wq(3); scl_m = 1'b0; wq(Q - 7);
    end else wq(Q);
    scl_m = 1'b1;
    if (g && gmode == 1) begin
      wq(5); sda_m = ~b; wq(3); sda_m = b; wq(Q - 8);
    end else wq(Q);
    wq(Q); scl_m = 1'b0; wq(Q);
  endtask

  task automatic read_bit(output logic b);
    sda_m = 1'b1; wq(Q); scl_m = 1'b1; wq(Q);
    b = sda_bus; wq(Q); scl_m = 1'b0; wq(Q);
  endtask

  task automatic send_byte(input logic [7:0] d, input int gbit, output bit ack);
    logic b;
    for (int i = 7; i >= 0; i--) write_bit(d[i], i == gbit);
    read_bit(b);
    ack = !b;
  endtask

  task automatic recv_byte(input bit mack, output logic [7:0] d);
    logic b;
    for (int i = 0; i < 8; i++) begin read_bit(b); d = {d[6:0], b}; end
    write_bit(!mack, 1'b0);
  endtask

  function automatic logic [7:0] idb(input logic [1:0] s, input bit rd);
    return {5'b10100, s, rd};
  endfunction

  task automatic do_write(input logic [7:0] a, input logic [7:0] d, input int gbit, output bit ok);
    bit a0, a1, a2;
    bus_start();
    send_byte(idb(strap_b, 1'b0), -1, a0);
    send_byte(a, -1, a1);
    send_byte(d, gbit, a2);
    bus_stop();
    ok = a0 && a1 && a2;
  endtask

  task automatic do_read_setup(input logic [7:0] a, output bit ok);
    bit a0, a1, a2;
    bus_start();
    send_byte(idb(strap_b, 1'b0), -1, a0);
    send_byte(a, -1, a1);
    scl_m = 1'b0;
    bus_start();
    send_byte(idb(strap_b, 1'b1), -1, a2);
    ok = a0 && a1 && a2;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog R1..R8 actual=running expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    bit ok, ack;
    logic [7:0] d, ea, ed;
    int wc;
    wq(3);
    // R1 reset state while held
    chk(sda_oe == 1'b0 && reg_wr_en == 1'b0, "R1 reset", {sda_oe, reg_wr_en}, 0);
    rst_n = 1'b1;
    wq(20);
    chk(sda_oe == 1'b0 && reg_wr_en == 1'b0, "R1 after reset", {sda_oe, reg_wr_en}, 0);

    // R2 sweep: every strap setting against every address pair
    for (int s = 0; s < 4; s++) begin
      strap_b = 2'(s);
      wq(Q);
      for (int a = 0; a < 4; a++) begin
        bus_start();
        send_byte(idb(2'(a), 1'b0), -1, ack);
        chk(ack == (a == s), "R2 id ack", ack, a == s);
        if (a != s) begin
          send_byte(8'h00, -1, ack);
          chk(!ack, "R2 no ack after mismatch", ack, 0);
        end
        bus_stop();
      end
    end
    // R2 wrong prefix
    bus_start();
    send_byte({5'b10110, strap_b, 1'b0}, -1, ack);
    chk(!ack, "R2 wrong prefix", ack, 0);
    bus_stop();

    strap_b = 2'b10;
    wq(Q);
    // R3 write sweep
    for (int k = 0; k < 12; k++) begin
      ea = 8'(k * 21 + 4);
      ed = 8'(k * 37 + 11);
      wc = wr_cnt;
      do_write(ea, ed, -1, ok);
      chk(ok, "R3 write acks", ok, 1);
      chk(wr_cnt == wc + 1 && last_wa == ea && last_wd == ed, "R3 write strobe",
          {wr_cnt - wc, last_wa, last_wd}, {1, ea, ed});
    end

    // R4 extra byte after data
    wc = wr_cnt;
    bus_start();
    send_byte(idb(strap_b, 1'b0), -1, ack);
    send_byte(8'hC3, -1, ack);
    send_byte(8'h96, -1, ack);
    send_byte(8'h11, -1, ack);
    chk(!ack, "R4 extra byte nack", ack, 0);
    bus_stop();
    chk(wr_cnt == wc + 1 && last_wd == 8'h96, "R4 single write", {wr_cnt - wc, last_wd}, {1, 8'h96});

    // R5 read back the sweep plus an untouched register
    for (int k = 0; k < 12; k++) begin
      ea = 8'(k * 21 + 4);
      ed = 8'(k * 37 + 11);
      do_read_setup(ea, ok);
      recv_byte(1'b0, d);
      bus_stop();
      chk(ok && d == ed, "R5 read data", {ok, d}, {1'b1, ed});
    end
    do_read_setup(8'hF1, ok);
    recv_byte(1'b0, d);
    bus_stop();
    chk(ok && d == (8'hF1 ^ 8'h5A), "R5 read default", d, 8'hF1 ^ 8'h5A);

    // R6 master ACK repeats register, NACK releases the line
    do_read_setup(8'hC3, ok);
    recv_byte(1'b1, d);
    chk(d == 8'h96, "R6 first byte", d, 8'h96);
    recv_byte(1'b1, d);
    chk(d == 8'h96, "R6 repeat byte", d, 8'h96);
    recv_byte(1'b0, d);
    chk(d == 8'h96, "R6 last byte", d, 8'h96);
    recv_byte(1'b0, d);
    chk(d == 8'hFF, "R6 released after nack", d, 8'hFF);
    bus_stop();

    // R7 byte after STOP without START
    scl_m = 1'b0; wq(Q);
    send_byte(idb(strap_b, 1'b0), -1, ack);
    chk(!ack && sda_oe == 1'b0, "R7 idle after stop", ack, 0);
    bus_stop();

    // R8 glitches inside the data byte of a write
    gmode = 1;
    wc = wr_cnt;
    do_write(8'h33, 8'hA5, 3, ok);
    chk(ok && wr_cnt == wc + 1 && last_wa == 8'h33 && last_wd == 8'hA5, "R8 sda spike",
        {ok, last_wa, last_wd}, {1'b1, 8'h33, 8'hA5});
    gmode = 2;
    wc = wr_cnt;
    do_write(8'h34, 8'h5C, 4, ok);
    chk(ok && wr_cnt == wc + 1 && last_wa == 8'h34 && last_wd == 8'h5C, "R8 scl spike",
        {ok, last_wa, last_wd}, {1'b1, 8'h34, 8'h5C});
    gmode = 0;

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule